// File: doc/BRIEF.md
# Double-Buffered Sensor Slot Memory

This block stores the sensor words that a serial receiver collects from up to eight slave devices, in two complete banks. At any moment one bank is hidden and one is visible. The receiver fills the hidden bank one slot at a time. The host reads and patches the visible bank through a byte port. When the receiver reports that a frame is finished, the two banks exchange roles, so the host always sees a whole frame and never a frame that is half written. A host-controlled hold input can freeze the current visible bank for as long as the host needs it. A swap request that arrives during a hold is dropped, not kept for later.

Each slot is 64 bits wide and is packed from the receiver's data word, CRC word and length settings. The sensor data sits at the bottom of the slot. The CRC sits at the very top of the slot, but only when CRC storage is enabled and the CRC fits above the data. Every other bit of the slot is zero. Each slot also carries a validity bit and two status bits. These live with the bank, so they change over in the same clock edge as the data.

Top module: `sensor_slot_dualbank`

## Requirements
- R1: After reset, every host byte read returns 0x00, `host_rdata` is 0x00, and all validity and status outputs are 0.
- R2: A host read of `host_addr` returns the visible bank's byte on `host_rdata` one cycle later. Address bits [5:3] select the slave and bits [2:0] select the byte, with byte 0 holding slot bits 7:0 and byte 7 holding bits 63:56. `host_rdata` holds its value in cycles with no read.
- R3: A receiver write (`rx_we`) goes into slot `rx_slave` of the hidden bank only. The visible data and the visible status do not change until a swap is accepted.
- R4: When `bank_swap_req` is high and `bank_hold` is low, the banks exchange roles from the next cycle. Data, validity (`rx_ok`) and both status bits (`rx_status`) change over at the same edge.
- R5: When `bank_swap_req` is high while `bank_hold` is high, the request is discarded. The visible bank stays the same, including after `bank_hold` goes low again.
- R6: Slot bits [L-1:0] hold `rx_data[L-1:0]`, where L is `cfg_data_len` and values above 64 are treated as 64. Slot bits that are not covered by the data or CRC fields are written as zero.
- R7: With `cfg_crc_off`=0, 1 ≤ C=`cfg_crc_len` ≤ 16 and L+C ≤ 64, slot bits [63:64-C] hold `rx_crc[C-1:0]`. In every other case no CRC bit is stored.
- R8: A host read in the same cycle as an accepted swap returns the byte from the bank that was visible before the swap.
- R9: An accepted swap clears all validity bits of the bank that becomes hidden. Two swaps with no receiver writes in between therefore leave every validity output at 0.
- R10: A host byte write (`host_wr`) changes only the addressed byte of the visible bank. A later read returns the written value.
- R11: A receiver write in the same cycle as an accepted swap lands in the bank that becomes visible. It is readable at once after the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_we | input | 1 | Receiver slot write strobe |
| rx_slave | input | 3 | Slave slot index for the write |
| rx_data | input | 64 | Sensor data word, right-justified |
| rx_crc | input | 16 | Received CRC bits, right-justified |
| rx_ok | input | 1 | Validity to store with the slot |
| rx_status | input | 2 | Two per-slave status bits to store |
| cfg_data_len | input | 7 | Data field length in bits |
| cfg_crc_len | input | 5 | CRC field length in bits |
| cfg_crc_off | input | 1 | 1 = never store CRC bits |
| bank_swap_req | input | 1 | Frame-complete swap request |
| bank_hold | input | 1 | Suppress bank swaps |
| host_rd | input | 1 | Host byte read strobe |
| host_wr | input | 1 | Host byte write strobe |
| host_addr | input | 6 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| host_valid | output | 8 | Visible bank validity, one bit per slave |
| host_status_lo | output | 8 | Visible bank status bit 0 per slave |
| host_status_hi | output | 8 | Visible bank status bit 1 per slave |

## Verification
The two functions that can land in the same cycle are the bank swap and the port accesses: a host read, a host write or a receiver write. Directed cycles drive a read together with an accepted swap and expect the byte from the bank that was visible before the swap. They also drive a receiver write together with a swap and expect that word to be readable right after the swap. Constrained-random cycles then mix all of these strobes with hold, and every read and every status output is compared against a two-bank model that follows the rules above.

// File: rtl/sensor_slot_pkg.sv
package sensor_slot_pkg;

    typedef logic [1:0] slot_status_t;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_id_t;

endpackage

// File: rtl/sensor_slot_pack.sv
module sensor_slot_pack #(
    parameter int SLOT_W = 64,
    parameter int CRC_W  = 16
) (
    input  logic [SLOT_W-1:0]         data_i,
    input  logic [CRC_W-1:0]          crc_i,
    input  logic [$clog2(SLOT_W):0]   data_len_i,
    input  logic [$clog2(CRC_W):0]    crc_len_i,
    input  logic                      crc_off_i,
    output logic [SLOT_W-1:0]         word_o
);
    localparam int LEN_W  = $clog2(SLOT_W) + 1;
    localparam int CLEN_W = $clog2(CRC_W) + 1;

    logic [LEN_W-1:0]  data_len_eff;
    logic [LEN_W-1:0]  crc_len_ext;
    logic [LEN_W:0]    field_sum;
    logic              crc_fits;
    logic              crc_keep;
    logic [SLOT_W-1:0] data_mask;
    logic [SLOT_W-1:0] crc_wide;
    logic [SLOT_W-1:0] crc_placed;

    always_comb begin
        // lengths beyond the slot saturate to the slot width
        data_len_eff = (data_len_i > LEN_W'(SLOT_W)) ? LEN_W'(SLOT_W) : data_len_i;
        crc_len_ext  = LEN_W'(crc_len_i);
        field_sum    = {1'b0, data_len_eff} + {1'b0, crc_len_ext};
        crc_fits     = (field_sum <= (LEN_W+1)'(SLOT_W));
        crc_keep     = !crc_off_i && (crc_len_i != '0)
                       && (crc_len_i <= CLEN_W'(CRC_W)) && crc_fits;
        data_mask    = ~({SLOT_W{1'b1}} << data_len_eff);
        crc_wide     = {{(SLOT_W-CRC_W){1'b0}}, crc_i};
        // CRC bits above crc_len are shifted out of the top of the slot
        crc_placed   = crc_wide << (LEN_W'(SLOT_W) - crc_len_ext);
        word_o       = (data_i & data_mask) | (crc_keep ? crc_placed : '0);
    end

endmodule

// File: rtl/sensor_slot_bankctl.sv
module sensor_slot_bankctl
    import sensor_slot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     swap_req_i,
    input  logic     hold_i,
    output bank_id_t vis_o,
    output logic     swap_take_o
);
    typedef struct packed {
        bank_id_t vis;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       take;

    always_comb begin
        st_d = st_q;
        // requests during hold are dropped, never remembered
        take = swap_req_i && !hold_i;
        if (take) begin
            st_d.vis = (st_q.vis == BANK_A) ? BANK_B : BANK_A;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vis: BANK_A};
        end else begin
            st_q <= st_d;
        end
    end

    assign vis_o       = st_q.vis;
    assign swap_take_o = take;

    assert_swap_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req_i && !hold_i) |=> (vis_o != $past(vis_o)));

    assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req_i && hold_i) |=> $stable(vis_o));

endmodule

// File: rtl/sensor_slot_bank.sv
module sensor_slot_bank
    import sensor_slot_pkg::*;
#(
    parameter int NSLV   = 8,
    parameter int SLOT_W = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we_i,
    input  logic [$clog2(NSLV)-1:0]             wslv_i,
    input  logic [SLOT_W-1:0]                   wword_i,
    input  logic                                wok_i,
    input  slot_status_t                        wst_i,
    input  logic                                bwe_i,
    input  logic [$clog2(NSLV)-1:0]             bslv_i,
    input  logic [$clog2(SLOT_W/8)-1:0]         bbyte_i,
    input  logic [7:0]                          bdata_i,
    input  logic                                clr_i,
    output logic [NSLV-1:0][SLOT_W-1:0]         data_o,
    output logic [NSLV-1:0]                     valid_o,
    output logic [NSLV-1:0][1:0]                stat_o
);
    typedef struct packed {
        logic [NSLV-1:0][SLOT_W-1:0] data;
        logic [NSLV-1:0]             valid;
        logic [NSLV-1:0][1:0]        stat;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.data[wslv_i]  = wword_i;
            st_d.valid[wslv_i] = wok_i;
            st_d.stat[wslv_i]  = wst_i;
        end
        if (bwe_i) begin
            st_d.data[bslv_i][{bbyte_i, 3'b000} +: 8] = bdata_i;
        end
        if (clr_i) begin
            st_d.valid = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign stat_o  = st_q.stat;

    // clearing and slot filling are steered to opposite banks by the top
    assert_clear_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> !we_i);

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !we_i) |=> (valid_o == '0));

endmodule

// File: rtl/sensor_slot_dualbank.sv
module sensor_slot_dualbank
    import sensor_slot_pkg::*;
#(
    parameter int NSLV   = 8,
    parameter int SLOT_W = 64,
    parameter int CRC_W  = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    rx_we,
    input  logic [$clog2(NSLV)-1:0]                 rx_slave,
    input  logic [SLOT_W-1:0]                       rx_data,
    input  logic [CRC_W-1:0]                        rx_crc,
    input  logic                                    rx_ok,
    input  logic [1:0]                              rx_status,
    input  logic [$clog2(SLOT_W):0]                 cfg_data_len,
    input  logic [$clog2(CRC_W):0]                  cfg_crc_len,
    input  logic                                    cfg_crc_off,
    input  logic                                    bank_swap_req,
    input  logic                                    bank_hold,
    input  logic                                    host_rd,
    input  logic                                    host_wr,
    input  logic [$clog2(NSLV*SLOT_W/8)-1:0]        host_addr,
    input  logic [7:0]                              host_wdata,
    output logic [7:0]                              host_rdata,
    output logic [NSLV-1:0]                         host_valid,
    output logic [NSLV-1:0]                         host_status_lo,
    output logic [NSLV-1:0]                         host_status_hi
);
    localparam int NBANK  = 2;
    localparam int BYTE_W = $clog2(SLOT_W/8);
    localparam int ADDR_W = $clog2(NSLV*SLOT_W/8);
    localparam int SLV_W  = $clog2(NSLV);

    typedef struct packed {
        logic [7:0] rdata;
    } rd_state_t;

    bank_id_t                      vis;
    logic                          swap_take;
    logic [SLOT_W-1:0]             pack_word;
    logic [SLV_W-1:0]              host_slv;
    logic [BYTE_W-1:0]             host_byte;
    logic [NSLV-1:0][SLOT_W-1:0]   bank_data  [NBANK];
    logic [NSLV-1:0]               bank_valid [NBANK];
    logic [NSLV-1:0][1:0]          bank_stat  [NBANK];
    rd_state_t                     rd_d, rd_q;

    assign host_slv  = host_addr[ADDR_W-1:BYTE_W];
    assign host_byte = host_addr[BYTE_W-1:0];

    sensor_slot_pack #(
        .SLOT_W (SLOT_W),
        .CRC_W  (CRC_W)
    ) u_pack (
        .data_i     (rx_data),
        .crc_i      (rx_crc),
        .data_len_i (cfg_data_len),
        .crc_len_i  (cfg_crc_len),
        .crc_off_i  (cfg_crc_off),
        .word_o     (pack_word)
    );

    sensor_slot_bankctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .swap_req_i  (bank_swap_req),
        .hold_i      (bank_hold),
        .vis_o       (vis),
        .swap_take_o (swap_take)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic is_vis;
        assign is_vis = (vis == bank_id_t'(g));

        sensor_slot_bank #(
            .NSLV   (NSLV),
            .SLOT_W (SLOT_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (rx_we && !is_vis),
            .wslv_i  (rx_slave),
            .wword_i (pack_word),
            .wok_i   (rx_ok),
            .wst_i   (rx_status),
            .bwe_i   (host_wr && is_vis),
            .bslv_i  (host_slv),
            .bbyte_i (host_byte),
            .bdata_i (host_wdata),
            .clr_i   (swap_take && is_vis),
            .data_o  (bank_data[g]),
            .valid_o (bank_valid[g]),
            .stat_o  (bank_stat[g])
        );
    end

    always_comb begin
        rd_d = rd_q;
        // sampled from the pre-edge visible bank, so a swap cannot tear it
        if (host_rd) begin
            rd_d.rdata = bank_data[vis][host_slv][{host_byte, 3'b000} +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        host_valid = bank_valid[vis];
        for (int s = 0; s < NSLV; s++) begin
            host_status_lo[s] = bank_stat[vis][s][0];
            host_status_hi[s] = bank_stat[vis][s][1];
        end
    end

    assign host_rdata = rd_q.rdata;

    assert_rdata_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    assert_pack_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_we && cfg_crc_off && (cfg_data_len < ($clog2(SLOT_W)+1)'(SLOT_W)))
        |-> ((pack_word >> cfg_data_len) == '0));

    assert_status_follows_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_swap_req && !bank_hold && !rx_we) |=> (host_valid == $past(bank_valid[~vis])));

endmodule

// File: tb/tb_sensor_slot_dualbank.sv
`timescale 1ns/1ps
module tb_sensor_slot_dualbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_we = 0;
    logic [2:0]  rx_slave = 0;
    logic [63:0] rx_data = 0;
    logic [15:0] rx_crc = 0;
    logic        rx_ok = 0;
    logic [1:0]  rx_status = 0;
    logic [6:0]  cfg_data_len = 7'd64;
    logic [4:0]  cfg_crc_len = 0;
    logic        cfg_crc_off = 1;
    logic        bank_swap_req = 0;
    logic        bank_hold = 0;
    logic        host_rd = 0;
    logic        host_wr = 0;
    logic [5:0]  host_addr = 0;
    logic [7:0]  host_wdata = 0;
    logic [7:0]  host_rdata;
    logic [7:0]  host_valid, host_status_lo, host_status_hi;

    int checks = 0;
    int fails  = 0;

    logic [63:0] m_data  [2][8];
    logic        m_valid [2][8];
    logic [1:0]  m_st    [2][8];
    int          m_vis = 0;

    always #10 clk = ~clk;

    sensor_slot_dualbank dut (
        .clk(clk), .rst_n(rst_n), .rx_we(rx_we), .rx_slave(rx_slave),
        .rx_data(rx_data), .rx_crc(rx_crc), .rx_ok(rx_ok), .rx_status(rx_status),
        .cfg_data_len(cfg_data_len), .cfg_crc_len(cfg_crc_len), .cfg_crc_off(cfg_crc_off),
        .bank_swap_req(bank_swap_req), .bank_hold(bank_hold), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_valid(host_valid),
        .host_status_lo(host_status_lo), .host_status_hi(host_status_hi)
    );

    function automatic logic [63:0] exp_pack(logic [63:0] d, logic [15:0] c,
                                             int dl, int cl, logic off);
        logic [63:0] r = '0;
        int  se = (dl > 64) ? 64 : dl;
        bit  on = !off && cl != 0 && cl <= 16 && (se + cl) <= 64;
        for (int i = 0; i < 64; i++) begin
            if (i < se) r[i] = d[i];
            else if (on && i >= 64 - cl) r[i] = c[i - (64 - cl)];
        end
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // inputs are set at a negedge; one edge is taken; outputs checked at the next negedge
    task automatic tick(string tag);
        logic [7:0] exp_rd;
        bit rd = host_rd;
        int hid = 1 - m_vis;
        logic [7:0] ev, el, eh;
        exp_rd = m_data[m_vis][host_addr[5:3]][{host_addr[2:0], 3'b000} +: 8];
        @(posedge clk);
        if (rx_we) begin
            m_data[hid][rx_slave]  = exp_pack(rx_data, rx_crc, int'(cfg_data_len),
                                              int'(cfg_crc_len), cfg_crc_off);
            m_valid[hid][rx_slave] = rx_ok;
            m_st[hid][rx_slave]    = rx_status;
        end
        if (host_wr) m_data[m_vis][host_addr[5:3]][{host_addr[2:0], 3'b000} +: 8] = host_wdata;
        if (bank_swap_req && !bank_hold) begin
            for (int s = 0; s < 8; s++) m_valid[m_vis][s] = 1'b0;
            m_vis = hid;
        end
        @(negedge clk);
        if (rd) check(host_rdata == exp_rd, {tag, " rdata"}, 64'(host_rdata), 64'(exp_rd));
        for (int s = 0; s < 8; s++) begin
            ev[s] = m_valid[m_vis][s];
            el[s] = m_st[m_vis][s][0];
            eh[s] = m_st[m_vis][s][1];
        end
        check(host_valid == ev, {tag, " valid"}, 64'(host_valid), 64'(ev));
        check({host_status_hi, host_status_lo} == {eh, el}, {tag, " status"},
              64'({host_status_hi, host_status_lo}), 64'({eh, el}));
        rx_we = 0; bank_swap_req = 0; host_rd = 0; host_wr = 0;
    endtask

    task automatic rx_put(int s, logic [63:0] d, logic [15:0] c, logic ok, logic [1:0] st);
        rx_we = 1; rx_slave = 3'(s); rx_data = d; rx_crc = c; rx_ok = ok; rx_status = st;
    endtask

    task automatic read_slot(int s, string tag);
        for (int b = 0; b < 8; b++) begin
            host_rd = 1; host_addr = 6'(s * 8 + b);
            tick(tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 8; s++) begin
                m_data[b][s] = '0; m_valid[b][s] = 0; m_st[b][s] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(host_rdata == 8'h00, "R1 rdata", 64'(host_rdata), 0);
        check(host_valid == 8'h00, "R1 valid", 64'(host_valid), 0);
        host_rd = 1; host_addr = 6'h3F; tick("R1 read");

        // R3 hidden write, then R4 swap and R2 byte order, R6 upper zero
        cfg_crc_off = 1; cfg_data_len = 7'd64;
        rx_put(3, 64'h8877_6655_4433_2211, 16'h0, 1, 2'b10); tick("R3 write");
        read_slot(3, "R3 hidden");
        bank_swap_req = 1; tick("R4 swap");
        check(host_valid == 8'h08, "R4 valid bit", 64'(host_valid), 64'h08);
        host_rd = 1; host_addr = 6'd24; tick("R2 byte0");
        check(host_rdata == 8'h11, "R2 byte0", 64'(host_rdata), 64'h11);
        host_rd = 1; host_addr = 6'd31; tick("R2 byte7");
        check(host_rdata == 8'h88, "R2 byte7", 64'(host_rdata), 64'h88);
        cfg_data_len = 7'd20;
        rx_put(5, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 1, 2'b01); tick("R6 write");
        bank_swap_req = 1; tick("R6 swap");
        read_slot(5, "R6 masked");

        // R7 CRC at top, and omitted when it does not fit or is disabled
        cfg_crc_off = 0; cfg_data_len = 7'd40; cfg_crc_len = 5'd8;
        rx_put(1, 64'hFFFF_FFFF_FFFF_FFFF, 16'h12A5, 1, 2'b11); tick("R7 write");
        cfg_data_len = 7'd60;
        rx_put(2, 64'h0, 16'hFFFF, 1, 2'b00); tick("R7 overlap");
        cfg_crc_off = 1; cfg_data_len = 7'd8;
        rx_put(4, 64'h0, 16'hFFFF, 0, 2'b00); tick("R7 off");
        bank_swap_req = 1; tick("R7 swap");
        host_rd = 1; host_addr = 6'd15; tick("R7 crc byte");
        check(host_rdata == 8'hA5, "R7 crc byte", 64'(host_rdata), 64'hA5);
        read_slot(1, "R7 slot1"); read_slot(2, "R7 slot2"); read_slot(4, "R7 slot4");

        // R5 hold drops the request
        bank_hold = 1; bank_swap_req = 1; tick("R5 held");
        bank_hold = 0; tick("R5 released");
        repeat (2) tick("R5 no queue");
        read_slot(1, "R5 visible");

        // R8 read together with swap returns the pre-swap byte
        host_rd = 1; host_addr = 6'd15; bank_swap_req = 1; tick("R8 read+swap");
        check(host_rdata == 8'hA5, "R8 preswap", 64'(host_rdata), 64'hA5);

        // R11 receiver write together with swap becomes visible at once
        cfg_data_len = 7'd64;
        rx_put(6, 64'hDEAD_BEEF_CAFE_F00D, 0, 1, 2'b10); bank_swap_req = 1;
        tick("R11 write+swap");
        host_rd = 1; host_addr = 6'd48; tick("R11 read");
        check(host_rdata == 8'h0D, "R11 byte0", 64'(host_rdata), 64'h0D);

        // R10 host write then readback
        host_wr = 1; host_addr = 6'd50; host_wdata = 8'h5A; tick("R10 write");
        host_rd = 1; host_addr = 6'd50; tick("R10 read");
        check(host_rdata == 8'h5A, "R10 readback", 64'(host_rdata), 64'h5A);
        read_slot(6, "R10 neighbours");

        // R9 two empty swaps leave no valid bits
        bank_swap_req = 1; tick("R9 swap1");
        bank_swap_req = 1; tick("R9 swap2");
        check(host_valid == 8'h00, "R9 cleared", 64'(host_valid), 0);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            cfg_data_len = 7'($urandom_range(0, 70));
            cfg_crc_len  = 5'($urandom_range(0, 17));
            cfg_crc_off  = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 9) < 4)
                rx_put($urandom_range(0, 7), {$urandom, $urandom}, 16'($urandom),
                       1'($urandom), 2'($urandom));
            bank_hold     = ($urandom_range(0, 9) < 3);
            bank_swap_req = ($urandom_range(0, 9) < 2);
            host_rd       = ($urandom_range(0, 1) == 1);
            host_wr       = ($urandom_range(0, 9) == 0);
            host_addr     = 6'($urandom);
            host_wdata    = 8'($urandom);
            tick("R2/R3/R4/R5/R7/R8/R9/R10/R11 random");
        end
        bank_hold = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule